// File: doc/BRIEF.md
# Multi-area static memory bus controller

This block turns single requests from a processor's internal request port into timed bus cycles on an external static memory bus. The external space is divided into areas by a three-bit field at the top of the address. Each decoded area has its own active-low chip select and its own timing set. That set holds an address-to-strobe setup of zero or one cycle, a three-bit wait code that gives the base number of wait cycles, and a chip-select hold of zero to three cycles after the strobe ends. Once the programmed waits have run out, an external active-low ready input can stretch the strobe for any number of cycles.

A read drives the output-enable strobe and captures the data bus in the strobe cycle that ends the access. A write drives one active-low strobe for each byte lane that is enabled, and drives the write data onto the bus for the whole access. When an access finishes, the block pulses a done flag. An address whose area field decodes to no area drives nothing on the bus, finishes at once and raises an error flag alongside done. Only one access is in flight at a time, and the request port stalls until that access finishes.

Top module: `xmem_area_ctrl`

## Requirements
- R1: The area is given by address bits [28:26]. Value 0 drives bus_cs_n[0] low and value 1 drives bus_cs_n[1] low, and no other chip select is low at the same time. bus_addr carries the accepted request address for the whole access, whatever the request port does while the access runs.
- R2: In a read access, bus_oe_n is low in every strobe cycle and high in all other cycles. bus_we_n stays all ones and bus_dout_en stays low. rsp_rdata in the done cycle equals the value that bus_din held in the final strobe cycle.
- R3: In a write access, bus_we_n[i] is low in the strobe cycles exactly when req_be[i] was 1. bus_oe_n stays high. bus_dout_en is high and bus_dout equals the request write data while the chip select is low.
- R4: The 3-bit wait code of the selected area, with values 0 to 7, gives 0, 1, 2, 3, 4, 6, 8 and 12 base wait cycles. With ready already asserted, the strobe lasts that count plus one cycle. bus_rdy_n is ignored during the base wait cycles.
- R5: After the base waits, every cycle in which bus_rdy_n is sampled high adds one more strobe cycle. There is no upper limit.
- R6: When the area's setup bit is 1, the chip select and address are driven for one cycle before the strobe. When the bit is 0, the strobe starts in the first cycle of the access.
- R7: The chip select stays low for as many cycles after the strobe as the area's 2-bit hold field gives (0 to 3). The strobes are high in those cycles.
- R8: rsp_done is high for exactly one cycle. That cycle is the first one after the access ends, in which every chip select is high. rsp_err is low for a decoded area.
- R9: An area field of 2 to 7 asserts no chip select and no strobe. rsp_done and rsp_err are both high in the second cycle after acceptance.
- R10: A request is taken only when req_ready is high. req_ready is low from the cycle after acceptance up to the done cycle, and requests presented in that time are not taken.
- R11: After reset, all chip selects and strobes are high, bus_dout_en is low, req_ready is high and rsp_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_addr | input | 29 | Request address; bits [28:26] select the area |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 8 | Byte-lane enables for a write |
| req_wdata | input | 64 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Undecoded area, valid with rsp_done |
| rsp_rdata | output | 64 | Captured read data |
| cfg_setup_en | input | 2 | Per-area setup cycle enable, bit i for area i |
| cfg_wait_code | input | 6 | Per-area 3-bit wait code, area i at bits [3i+2:3i] |
| cfg_hold | input | 4 | Per-area 2-bit hold count, area i at bits [2i+1:2i] |
| bus_cs_n | output | 2 | Active-low chip selects, one per area |
| bus_oe_n | output | 1 | Active-low read strobe / output enable |
| bus_we_n | output | 8 | Active-low byte-lane write strobes |
| bus_addr | output | 29 | External address |
| bus_dout | output | 64 | Write data to the bus |
| bus_dout_en | output | 1 | Data bus drive enable |
| bus_din | input | 64 | Read data from the bus |
| bus_rdy_n | input | 1 | Synchronous active-low ready |

## Verification
The hardest case to bring about is a not-ready that arrives exactly as the base waits run out. The same input must have no effect one cycle earlier and must add cycles one cycle later. The bench holds bus_rdy_n high through the setup and base-wait cycles and for a chosen number of extra cycles, counting strobe cycles from its own model of the access. This shows that the waits are neither shortened nor stretched by an early not-ready, and that each late not-ready adds exactly one cycle. Throughout every access it also presents a conflicting request to an undecoded area, so any wrongly taken request would show up on the chip selects, the address or the error flag.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int WAIT_CODE_W = 3;
  localparam int WAIT_CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RDY   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_ERR   = 3'd5
  } phase_t;

  // code 0..3 -> 0..3 ; code 4..7 -> 4, 6, 8, 12
  function automatic logic [WAIT_CNT_W-1:0] wait_cycles(input logic [WAIT_CODE_W-1:0] code);
    logic [WAIT_CNT_W-1:0] base;
    if (!code[2]) begin
      return {1'b0, code};
    end
    base = 4'd4 + {2'b00, code[0], 1'b0};
    return base << code[1];
  endfunction

endpackage

// File: rtl/xmem_area_decode.sv
module xmem_area_decode #(
  parameter int ADDR_W    = 29,
  parameter int AREA_LO   = 26,
  parameter int AREA_W    = 3,
  parameter int NUM_AREAS = 2,
  localparam int IDX_W    = $clog2(NUM_AREAS)
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 area_hit,
  output logic [IDX_W-1:0]     area_idx,
  output logic [NUM_AREAS-1:0] area_oh
);

  logic [AREA_W-1:0] field;

  assign field    = addr[AREA_LO +: AREA_W];
  assign area_hit = ({1'b0, field} < (AREA_W+1)'(NUM_AREAS));
  assign area_idx = field[IDX_W-1:0];

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_oh
    assign area_oh[i] = (field == AREA_W'(i));
  end

endmodule

// File: rtl/xmem_cfg_select.sv
module xmem_cfg_select
  import xmem_pkg::*;
#(
  parameter int NUM_AREAS = 2,
  parameter int HOLD_W    = 2,
  localparam int IDX_W    = $clog2(NUM_AREAS)
) (
  input  logic [IDX_W-1:0]                 area_idx,
  input  logic [NUM_AREAS-1:0]             cfg_setup_en,
  input  logic [NUM_AREAS*WAIT_CODE_W-1:0] cfg_wait_code,
  input  logic [NUM_AREAS*HOLD_W-1:0]      cfg_hold,
  output logic                             sel_setup,
  output logic [WAIT_CNT_W-1:0]            sel_waits,
  output logic [HOLD_W-1:0]                sel_hold
);

  logic [WAIT_CODE_W-1:0] code;

  assign code      = cfg_wait_code[area_idx*WAIT_CODE_W +: WAIT_CODE_W];
  assign sel_setup = cfg_setup_en[area_idx];
  assign sel_waits = wait_cycles(code);
  assign sel_hold  = cfg_hold[area_idx*HOLD_W +: HOLD_W];

endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
  import xmem_pkg::*;
#(
  parameter int HOLD_W = 2,
  localparam int CW    = (HOLD_W > WAIT_CNT_W) ? HOLD_W : WAIT_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  area_hit,
  input  logic                  cfg_setup,
  input  logic [WAIT_CNT_W-1:0] cfg_waits,
  input  logic [HOLD_W-1:0]     cfg_hold,
  input  logic                  rdy_n,
  output phase_t                nxt_phase,
  output logic                  accept,
  output logic                  capture,
  output logic                  idle,
  output logic                  done_q,
  output logic                  err_q
);

  phase_t                phase_q;
  logic [CW-1:0]         cnt_q, nxt_cnt;
  logic [WAIT_CNT_W-1:0] waits_q;
  logic [HOLD_W-1:0]     hold_q;
  logic                  finish;

  assign idle   = (phase_q == ST_IDLE);
  assign accept = idle && req_valid;

  always_comb begin
    nxt_phase = phase_q;
    nxt_cnt   = cnt_q;
    capture   = 1'b0;
    finish    = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!area_hit) begin
            nxt_phase = ST_ERR;
          end else if (cfg_setup) begin
            nxt_phase = ST_SETUP;
          end else if (cfg_waits != '0) begin
            nxt_phase = ST_WAIT;
            nxt_cnt   = CW'(cfg_waits);
          end else begin
            nxt_phase = ST_RDY;
          end
        end
      end
      ST_SETUP: begin
        if (waits_q != '0) begin
          nxt_phase = ST_WAIT;
          nxt_cnt   = CW'(waits_q);
        end else begin
          nxt_phase = ST_RDY;
        end
      end
      ST_WAIT: begin
        if (cnt_q == CW'(1)) begin
          nxt_phase = ST_RDY;
        end else begin
          nxt_cnt = cnt_q - CW'(1);
        end
      end
      ST_RDY: begin
        if (!rdy_n) begin
          capture = 1'b1;
          if (hold_q != '0) begin
            nxt_phase = ST_HOLD;
            nxt_cnt   = CW'(hold_q);
          end else begin
            nxt_phase = ST_IDLE;
            finish    = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q == CW'(1)) begin
          nxt_phase = ST_IDLE;
          finish    = 1'b1;
        end else begin
          nxt_cnt = cnt_q - CW'(1);
        end
      end
      ST_ERR: begin
        nxt_phase = ST_IDLE;
        finish    = 1'b1;
      end
      default: nxt_phase = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      waits_q <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= nxt_phase;
      cnt_q   <= nxt_cnt;
      done_q  <= finish;
      err_q   <= (phase_q == ST_ERR);
      if (accept) begin
        waits_q <= cfg_waits;
        hold_q  <= cfg_hold;
      end
    end
  end

endmodule

// File: rtl/xmem_pin_drive.sv
module xmem_pin_drive
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 29,
  parameter int DATA_W    = 64,
  parameter int NUM_AREAS = 2,
  localparam int LANES    = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  phase_t               nxt_phase,
  input  logic                 accept,
  input  logic [NUM_AREAS-1:0] act_oh,
  input  logic                 act_write,
  input  logic [LANES-1:0]     act_be,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [NUM_AREAS-1:0] bus_cs_n,
  output logic                 bus_oe_n,
  output logic [LANES-1:0]     bus_we_n,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_dout_en
);

  logic active, strobe;

  assign active = (nxt_phase == ST_SETUP) || (nxt_phase == ST_WAIT) ||
                  (nxt_phase == ST_RDY)   || (nxt_phase == ST_HOLD);
  assign strobe = (nxt_phase == ST_WAIT) || (nxt_phase == ST_RDY);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n    <= '1;
      bus_oe_n    <= 1'b1;
      bus_we_n    <= '1;
      bus_addr    <= '0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      bus_cs_n    <= active ? ~act_oh : '1;
      bus_oe_n    <= ~(strobe && !act_write);
      bus_we_n    <= (strobe && act_write) ? ~act_be : '1;
      bus_dout_en <= active && act_write;
      if (accept) begin
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/xmem_area_ctrl.sv
module xmem_area_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 29,
  parameter int DATA_W    = 64,
  parameter int NUM_AREAS = 2,
  parameter int AREA_LO   = 26,
  parameter int AREA_W    = 3,
  parameter int HOLD_W    = 2,
  localparam int LANES    = DATA_W / 8,
  localparam int IDX_W    = $clog2(NUM_AREAS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic                             req_write,
  input  logic [LANES-1:0]                 req_be,
  input  logic [DATA_W-1:0]                req_wdata,
  output logic                             rsp_done,
  output logic                             rsp_err,
  output logic [DATA_W-1:0]                rsp_rdata,
  input  logic [NUM_AREAS-1:0]             cfg_setup_en,
  input  logic [NUM_AREAS*WAIT_CODE_W-1:0] cfg_wait_code,
  input  logic [NUM_AREAS*HOLD_W-1:0]      cfg_hold,
  output logic [NUM_AREAS-1:0]             bus_cs_n,
  output logic                             bus_oe_n,
  output logic [LANES-1:0]                 bus_we_n,
  output logic [ADDR_W-1:0]                bus_addr,
  output logic [DATA_W-1:0]                bus_dout,
  output logic                             bus_dout_en,
  input  logic [DATA_W-1:0]                bus_din,
  input  logic                             bus_rdy_n
);

  logic                  area_hit;
  logic [IDX_W-1:0]      area_idx;
  logic [NUM_AREAS-1:0]  area_oh;
  logic                  sel_setup;
  logic [WAIT_CNT_W-1:0] sel_waits;
  logic [HOLD_W-1:0]     sel_hold;
  phase_t                nxt_phase;
  logic                  accept, capture, idle;

  logic [NUM_AREAS-1:0]  oh_q;
  logic                  write_q;
  logic [LANES-1:0]      be_q;
  logic [NUM_AREAS-1:0]  act_oh;
  logic                  act_write;
  logic [LANES-1:0]      act_be;

  xmem_area_decode #(
    .ADDR_W(ADDR_W), .AREA_LO(AREA_LO), .AREA_W(AREA_W), .NUM_AREAS(NUM_AREAS)
  ) decode_i (
    .addr(req_addr), .area_hit(area_hit), .area_idx(area_idx), .area_oh(area_oh)
  );

  xmem_cfg_select #(
    .NUM_AREAS(NUM_AREAS), .HOLD_W(HOLD_W)
  ) cfg_i (
    .area_idx(area_idx), .cfg_setup_en(cfg_setup_en), .cfg_wait_code(cfg_wait_code),
    .cfg_hold(cfg_hold), .sel_setup(sel_setup), .sel_waits(sel_waits), .sel_hold(sel_hold)
  );

  xmem_phase_fsm #(
    .HOLD_W(HOLD_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .area_hit(area_hit),
    .cfg_setup(sel_setup), .cfg_waits(sel_waits), .cfg_hold(sel_hold),
    .rdy_n(bus_rdy_n), .nxt_phase(nxt_phase), .accept(accept), .capture(capture),
    .idle(idle), .done_q(rsp_done), .err_q(rsp_err)
  );

  assign req_ready = idle;

  // request attributes: fresh on the accepting edge, held afterwards
  assign act_oh    = accept ? area_oh   : oh_q;
  assign act_write = accept ? req_write : write_q;
  assign act_be    = accept ? req_be    : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_q      <= '0;
      write_q   <= 1'b0;
      be_q      <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        oh_q    <= area_oh;
        write_q <= req_write;
        be_q    <= req_be;
      end
      if (capture && !write_q) begin
        rsp_rdata <= bus_din;
      end
    end
  end

  xmem_pin_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_AREAS(NUM_AREAS)
  ) pins_i (
    .clk(clk), .rst(rst), .nxt_phase(nxt_phase), .accept(accept),
    .act_oh(act_oh), .act_write(act_write), .act_be(act_be),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );

endmodule

// File: rtl/xmem_area_chk.sv
module xmem_area_chk #(
  parameter int ADDR_W    = 29,
  parameter int NUM_AREAS = 2,
  parameter int LANES     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_done,
  input logic                 rsp_err,
  input logic [NUM_AREAS-1:0] bus_cs_n,
  input logic                 bus_oe_n,
  input logic [LANES-1:0]     bus_we_n,
  input logic [ADDR_W-1:0]    bus_addr
);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R1

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_addr)); // R1

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !(&bus_we_n)) |-> !(&bus_cs_n)); // R2

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> (&bus_we_n)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R8

  AST_CS_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (&bus_cs_n)); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done); // R9

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10

endmodule

bind xmem_area_ctrl xmem_area_chk #(
  .ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS), .LANES(LANES)
) chk_i (.*);

// File: tb/xmem_area_ctrl_tb_top.sv
module xmem_area_ctrl_tb_top;

  localparam int ADDR_W = 29;
  localparam int DATA_W = 64;
  localparam int LANES  = 8;
  localparam int NA     = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [LANES-1:0]  req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_done, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;
  logic [NA-1:0]     cfg_setup_en = '0;
  logic [NA*3-1:0]   cfg_wait_code = '0;
  logic [NA*2-1:0]   cfg_hold = '0;
  logic [NA-1:0]     bus_cs_n;
  logic              bus_oe_n;
  logic [LANES-1:0]  bus_we_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_dout_en;
  logic [DATA_W-1:0] bus_din = '0;
  logic              bus_rdy_n = 1'b0;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  xmem_area_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_setup_en(cfg_setup_en), .cfg_wait_code(cfg_wait_code), .cfg_hold(cfg_hold),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wmap(input int code);
    case (code)
      4: return 4;
      5: return 6;
      6: return 8;
      7: return 12;
      default: return code;
    endcase
  endfunction

  // one access; a = area field, s = setup, c = wait code, h = hold, x = extra not-ready cycles
  task automatic run_access(input int a, input int s, input int c, input int h, input bit w,
                            input int x, input logic [7:0] be, input logic [63:0] data,
                            input logic [25:0] low);
    int  wt;
    bit  err;
    int  tdone;
    logic [ADDR_W-1:0] addr;
    logic [63:0] din;
    wt    = wmap(c);
    err   = (a >= NA);
    tdone = err ? 2 : s + wt + x + 1 + h + 1;
    addr  = {3'(a), low};
    din   = {data[31:0], data[63:32]} ^ 64'hA5A5_0F0F_3C3C_9696;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
    cfg_setup_en  = '0;
    cfg_wait_code = 6'b111_111;
    cfg_hold      = 4'b11_11;
    if (!err) begin
      // other area gets opposite settings so a wrong index shows up
      cfg_setup_en[a]      = 1'(s);
      cfg_setup_en[1-a]    = 1'(1 - s);
      cfg_wait_code[a*3+:3] = 3'(c);
      cfg_wait_code[(1-a)*3+:3] = 3'(7 - c);
      cfg_hold[a*2+:2]     = 2'(h);
      cfg_hold[(1-a)*2+:2] = 2'(3 - h);
    end
    req_addr  = addr;
    req_write = w;
    req_be    = be;
    req_wdata = data;
    bus_din   = din;
    req_valid = 1'b1;
    bus_rdy_n = 1'b1;
    @(posedge clk);
    for (int t = 1; t <= tdone; t++) begin
      int    ph;
      int    k;
      string tag;
      bit    act, strb;
      logic [NA-1:0]    exp_cs;
      logic             exp_oe;
      logic [LANES-1:0] exp_we;
      @(negedge clk);
      k = t - s;
      if (err)                       ph = (t == 1) ? 5 : 4;
      else if (t <= s)               ph = 0;
      else if (k <= wt)              ph = 1;
      else if (k <= wt + x + 1)      ph = 2;
      else if (t < tdone)            ph = 3;
      else                           ph = 4;
      case (ph)
        0: tag = "R6 setup";
        1: tag = "R4 base wait";
        2: tag = "R5 ready stretch";
        3: tag = "R7 hold";
        5: tag = "R9 undecoded";
        default: tag = err ? "R9 done" : "R8 done";
      endcase
      act    = (ph <= 3);
      strb   = (ph == 1) || (ph == 2);
      exp_cs = act ? ~(NA'(1) << a) : '1;
      exp_oe = (strb && !w) ? 1'b0 : 1'b1;
      exp_we = (strb && w) ? ~be : '1;
      chk(bus_cs_n == exp_cs, {tag, " R1 chip select"}, 64'(bus_cs_n), 64'(exp_cs));
      chk(bus_oe_n == exp_oe, {tag, " R2 read strobe"}, 64'(bus_oe_n), 64'(exp_oe));
      chk(bus_we_n == exp_we, {tag, " R3 write strobes"}, 64'(bus_we_n), 64'(exp_we));
      chk(req_ready == (ph == 4), {tag, " R10 stall"}, 64'(req_ready), 64'(ph == 4));
      chk(rsp_done == (ph == 4), {tag, " done flag"}, 64'(rsp_done), 64'(ph == 4));
      if (act) begin
        chk(bus_addr == addr, "R1 address held", 64'(bus_addr), 64'(addr));
        chk(bus_dout_en == w, w ? "R3 drive enable" : "R2 no drive", 64'(bus_dout_en), 64'(w));
        if (w) chk(bus_dout == data, "R3 write data", bus_dout, data);
      end
      if (ph == 4) begin
        chk(rsp_err == err, err ? "R9 error flag" : "R8 no error", 64'(rsp_err), 64'(err));
        if (!err && !w) chk(rsp_rdata == din, "R2 read data", rsp_rdata, din);
      end
      // inputs for the edge that ends this cycle
      if (ph == 0 || ph == 1) bus_rdy_n = 1'b1;
      else if (ph == 2)       bus_rdy_n = (k <= wt + x) ? 1'b1 : 1'b0;
      else                    bus_rdy_n = 1'b0;
      if (ph != 4) begin
        req_valid = 1'b1;
        req_addr  = {3'd5, ~low};
        req_write = ~w;
        req_be    = ~be;
        req_wdata = ~data;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    int n;
    n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_cs_n == '1, "R11 reset chip selects", 64'(bus_cs_n), 64'h3);
    chk(bus_oe_n == 1'b1, "R11 reset read strobe", 64'(bus_oe_n), 64'd1);
    chk(bus_we_n == '1, "R11 reset write strobes", 64'(bus_we_n), 64'hFF);
    chk(bus_dout_en == 1'b0, "R11 reset drive enable", 64'(bus_dout_en), 64'd0);
    chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_done == 1'b0, "R11 reset done", 64'(rsp_done), 64'd0);

    for (int a = 0; a < NA; a++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 8; c++)
          for (int h = 0; h < 4; h++)
            for (int w = 0; w < 2; w++)
              for (int xi = 0; xi < 2; xi++) begin
                logic [7:0]  be;
                logic [63:0] data;
                be   = 8'(n * 29 + 7);
                if (be == 8'h00) be = 8'h5A;
                data = {32'(n * 32'h9E37_79B9), 32'(n) ^ 32'hC0FF_EE11};
                run_access(a, s, c, h, 1'(w), xi * 2, be, data, 26'(n * 4099));
                n++;
              end

    // long ready stretch on both areas
    run_access(0, 1, 7, 3, 1'b0, 9, 8'hFF, 64'h0123_4567_89AB_CDEF, 26'h155_5555);
    run_access(1, 0, 0, 0, 1'b1, 7, 8'h81, 64'hFEDC_BA98_7654_3210, 26'h2AA_AAAA);

    for (int a = 2; a < 8; a++)
      for (int w = 0; w < 2; w++)
        run_access(a, 1, 7, 3, 1'(w), 0, 8'h3C, 64'(a * 1000 + w), 26'(a * 77));

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, requirement R10 progress act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule